// File: doc/BRIEF.md
# Write Delay Centering Sequencer

This block trains the write-timing delay of up to four lane groups on one memory channel. Each delay setting is a three-level code: an outer count (two bits), a middle count that wraps at 12 in the fast clock mode and at 11 in the slow mode, and a three-bit fine count. The sequencer walks each group's code across the passing window and settles on its centre. It issues one test at a time to an external write/readback checker and reads back a single pass or fail bit.

Every group starts from the code already held in its current configuration word. The sequencer finds the first passing setting, which is the lower edge. It then finds the first failing setting beyond the window, which is the upper edge. It reports the linear midpoint of the two as a complete configuration word. When it encodes a word, the sequencer adds a band field derived from the middle count, and in fast mode it clamps the fine value near one particular middle-count boundary. A run covers all groups in ascending order. A run stops early on a code overflow or on a window that is too narrow, and the matching error flag stays set until the next start.

Top module: `wr_delay_center`

## Requirements
- R1: A position is kept as linear units lin = (f*M + t)*8 + p, where M is 12 in fast mode and 11 otherwise. Eight fine steps carry into t, and t carries into f at M. Every word on test_word and res_word has t below M.
- R2: If a position to be tested has f outside 0..3 (lin < 0 or lin >= 32*M), err_overflow is set, no request is issued, run_done pulses and the run ends. The flag holds until the next accepted start.
- R3: A group's first tested position is t = init bits 15:12, p = init bits 10:8, f = (init bits 3:2) - 1, normalized.
- R4: Lower search: t is raised by one until a test passes. Then t always steps back by one, and p is raised by one until a test passes. That position is the lower edge.
- R5: The upper search begins at lower + 3 t steps with the same p and f. A failure there sets err_narrow and ends the run with run_done. The flag holds until the next start.
- R6: From the upper start, t is raised until a test fails, then stepped back by one. That position is tested again, and p is raised until a test fails. The failing position is the upper edge.
- R7: The group result is floor((lower + upper)/2) in linear units, converted back to f, t and p.
- R8: Word encoding: t in bits 31:28, p in 26:24, f in 19:18, band in 17:16. Every other bit is copied from the group's init word.
- R9: band = 2'b11 when t <= L, 2'b01 when t > H, else 2'b00. (L,H) is (2,9) in fast mode and (1,6) in slow mode.
- R10: In fast mode the p field is written as 4 when t=9 and p>=4, or when t=10 and p<4.
- R11: Groups are handled in ascending order. A group whose two masks are both zero gets no request and no result. Every handled group ends with one res_valid pulse carrying its index and word.
- R12: test_req stays high with a stable test_word and test_grp until test_done. start is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted when idle) |
| fast_mode | input | 1 | Clock mode, sampled at start |
| grp_mask_a | input | NGRP*MASK_W | First lane-select mask per group |
| grp_mask_b | input | NGRP*MASK_W | Second lane-select mask per group |
| init_words | input | NGRP*32 | Current configuration word per group |
| test_req | output | 1 | Test request, held until test_done |
| test_grp | output | GW | Group under test |
| test_word | output | 32 | Encoded configuration word to test |
| test_done | input | 1 | Checker finished the current test |
| test_pass | input | 1 | Result of the test, valid with test_done |
| res_valid | output | 1 | One-cycle pulse with a group result |
| res_grp | output | GW | Group of the result |
| res_word | output | 32 | Centred configuration word |
| busy | output | 1 | Run in progress |
| run_done | output | 1 | One-cycle pulse at end of run |
| err_overflow | output | 1 | Sticky: outer count left 0..3 |
| err_narrow | output | 1 | Sticky: window narrower than 3 t steps |

## Verification
The hardest case to reach is a centre that lands on middle count 9 or 10 in fast mode, where the fine clamp shows up. The checker decides pass or fail from the clamped word, so a lower or upper edge near that boundary can shift. A directed run places a window from linear 60 to 94 in fast mode, which centres at t=9, p=5. Random windows and start words are checked against a bench search model that is fed the same pass function. That model also drives runs into the overflow and narrow-window exits.

// File: rtl/wdc_pkg.sv
package wdc_pkg;
    localparam int WORD_W    = 32;
    localparam int T_BITS    = 4;
    localparam int P_BITS    = 3;
    localparam int F_BITS    = 2;
    localparam int F_LEVELS  = 1 << F_BITS;
    // destination field positions
    localparam int T_LSB     = 28;
    localparam int P_LSB     = 24;
    localparam int F_LSB     = 18;
    localparam int B_LSB     = 16;
    // source field positions in the starting word
    localparam int SRC_T_LSB = 12;
    localparam int SRC_P_LSB = 8;
    localparam int SRC_F_LSB = 2;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SEL, ST_ISSUE, ST_WAIT, ST_GDONE, ST_END
    } wdc_st_e;

    typedef enum logic [2:0] {
        PH_LO_T, PH_LO_P, PH_UP_CHK, PH_UP_T, PH_UP_P
    } wdc_ph_e;
endpackage

// File: rtl/wdc_norm.sv
module wdc_norm
    import wdc_pkg::*;
#(
    parameter int LIN_W = 12
) (
    input  logic [LIN_W-1:0]  lin,
    input  logic [T_BITS-1:0] tmod,
    output logic [F_BITS-1:0] f,
    output logic [T_BITS-1:0] t,
    output logic [P_BITS-1:0] p,
    output logic              ovf
);
    logic [LIN_W-1:0] span;
    logic [LIN_W-1:0] full;
    logic [LIN_W-1:0] base;
    logic [LIN_W-1:0] rem;

    always_comb begin
        span = LIN_W'(tmod) << P_BITS;
        full = LIN_W'(F_LEVELS) * span;
        ovf  = lin[LIN_W-1] || (lin >= full);
        f    = '0;
        base = '0;
        for (int k = 1; k < F_LEVELS; k++) begin
            if (lin >= LIN_W'(k) * span) begin
                f    = F_BITS'(k);
                base = LIN_W'(k) * span;
            end
        end
        rem = lin - base;
        t   = rem[P_BITS +: T_BITS];
        p   = rem[P_BITS-1:0];
    end
endmodule

// File: rtl/wdc_encode.sv
module wdc_encode
    import wdc_pkg::*;
#(
    parameter int LO_FAST = 2,
    parameter int HI_FAST = 9,
    parameter int LO_SLOW = 1,
    parameter int HI_SLOW = 6,
    parameter int CLAMP_T = 9
) (
    input  logic [WORD_W-1:0] base,
    input  logic [T_BITS-1:0] t,
    input  logic [P_BITS-1:0] p,
    input  logic [F_BITS-1:0] f,
    input  logic              fast,
    output logic [WORD_W-1:0] word
);
    localparam logic [P_BITS-1:0] P_HALF = P_BITS'(1 << (P_BITS - 1));
    localparam logic [WORD_W-1:0] FIELD_MASK =
        (WORD_W'((1 << T_BITS) - 1) << T_LSB) |
        (WORD_W'((1 << P_BITS) - 1) << P_LSB) |
        (WORD_W'((1 << F_BITS) - 1) << F_LSB) |
        (WORD_W'(3) << B_LSB);

    logic [P_BITS-1:0] p_eff;
    logic [T_BITS-1:0] lo_lim, hi_lim;
    logic [1:0]        band;

    always_comb begin
        p_eff = p;
        if (fast && (((t == T_BITS'(CLAMP_T)) && (p >= P_HALF)) ||
                     ((t == T_BITS'(CLAMP_T + 1)) && (p < P_HALF))))
            p_eff = P_HALF;
        lo_lim = fast ? T_BITS'(LO_FAST) : T_BITS'(LO_SLOW);
        hi_lim = fast ? T_BITS'(HI_FAST) : T_BITS'(HI_SLOW);
        if (t <= lo_lim)      band = 2'b11;
        else if (t > hi_lim)  band = 2'b01;
        else                  band = 2'b00;
        word = base & ~FIELD_MASK;
        word[T_LSB +: T_BITS] = t;
        word[P_LSB +: P_BITS] = p_eff;
        word[F_LSB +: F_BITS] = f;
        word[B_LSB +: 2]      = band;
    end
endmodule

// File: rtl/wr_delay_center.sv
module wr_delay_center
    import wdc_pkg::*;
#(
    parameter int NGRP      = 4,
    parameter int MASK_W    = 32,
    parameter int TMOD_FAST = 12,
    parameter int TMOD_SLOW = 11,
    parameter int UP_T_OFS  = 3,
    localparam int GW       = (NGRP > 1) ? $clog2(NGRP) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     fast_mode,
    input  logic [NGRP*MASK_W-1:0]   grp_mask_a,
    input  logic [NGRP*MASK_W-1:0]   grp_mask_b,
    input  logic [NGRP*WORD_W-1:0]   init_words,
    output logic                     test_req,
    output logic [GW-1:0]            test_grp,
    output logic [WORD_W-1:0]        test_word,
    input  logic                     test_done,
    input  logic                     test_pass,
    output logic                     res_valid,
    output logic [GW-1:0]            res_grp,
    output logic [WORD_W-1:0]        res_word,
    output logic                     busy,
    output logic                     run_done,
    output logic                     err_overflow,
    output logic                     err_narrow
);
    localparam int GCW    = $clog2(NGRP + 1);
    localparam int LIN_W  = 12;
    localparam logic [LIN_W-1:0] STEP_T = LIN_W'(1 << P_BITS);
    localparam logic [LIN_W-1:0] STEP_P = LIN_W'(1);
    localparam logic [LIN_W-1:0] UP_OFS = LIN_W'(UP_T_OFS << P_BITS);

    typedef struct packed {
        wdc_st_e          st;
        wdc_ph_e          ph;
        logic [GCW-1:0]   grp;
        logic [LIN_W-1:0] lin;
        logic [LIN_W-1:0] lower;
        logic             fast;
        logic             e_ovf;
        logic             e_nar;
    } ctl_t;

    ctl_t c_d, c_q;

    // group selection: a group is live when either mask has a set bit
    logic [NGRP-1:0] grp_live;
    for (genvar g = 0; g < NGRP; g++) begin : g_live
        assign grp_live[g] = (|grp_mask_a[g*MASK_W +: MASK_W]) |
                             (|grp_mask_b[g*MASK_W +: MASK_W]);
    end

    logic [GW-1:0]     grp_idx;
    logic [WORD_W-1:0] cur_init;
    logic [T_BITS-1:0] tmod_w;
    logic [F_BITS-1:0] n_f;
    logic [T_BITS-1:0] n_t;
    logic [P_BITS-1:0] n_p;
    logic              n_ovf;
    logic [WORD_W-1:0] enc_word;
    logic signed [LIN_W-1:0] fs, tms, tss, pss, lin_start, mid;

    assign grp_idx  = c_q.grp[GW-1:0];
    assign cur_init = init_words[grp_idx*WORD_W +: WORD_W];
    assign tmod_w   = c_q.fast ? T_BITS'(TMOD_FAST) : T_BITS'(TMOD_SLOW);

    wdc_norm #(.LIN_W(LIN_W)) u_norm (
        .lin (c_q.lin),
        .tmod(tmod_w),
        .f   (n_f),
        .t   (n_t),
        .p   (n_p),
        .ovf (n_ovf)
    );

    wdc_encode u_enc (
        .base(cur_init),
        .t   (n_t),
        .p   (n_p),
        .f   (n_f),
        .fast(c_q.fast),
        .word(enc_word)
    );

    always_comb begin
        fs  = LIN_W'(cur_init[SRC_F_LSB +: F_BITS]) - LIN_W'(1);
        tms = LIN_W'(tmod_w);
        tss = LIN_W'(cur_init[SRC_T_LSB +: T_BITS]);
        pss = LIN_W'(cur_init[SRC_P_LSB +: P_BITS]);
        lin_start = (((fs * tms) + tss) <<< P_BITS) + pss;
        mid = ($signed(c_q.lower) + $signed(c_q.lin)) >>> 1;

        c_d = c_q;
        unique case (c_q.st)
            ST_IDLE: begin
                if (start) begin
                    c_d.st    = ST_SEL;
                    c_d.grp   = '0;
                    c_d.fast  = fast_mode;
                    c_d.e_ovf = 1'b0;
                    c_d.e_nar = 1'b0;
                end
            end
            ST_SEL: begin
                if (c_q.grp >= GCW'(NGRP)) begin
                    c_d.st = ST_END;
                end else if (!grp_live[grp_idx]) begin
                    c_d.grp = c_q.grp + 1'b1;
                end else begin
                    c_d.lin = lin_start;
                    c_d.ph  = PH_LO_T;
                    c_d.st  = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (n_ovf) begin
                    c_d.e_ovf = 1'b1;
                    c_d.st    = ST_END;
                end else begin
                    c_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (test_done) begin
                    c_d.st = ST_ISSUE;
                    unique case (c_q.ph)
                        PH_LO_T: begin
                            if (test_pass) begin
                                c_d.lin = c_q.lin - STEP_T;
                                c_d.ph  = PH_LO_P;
                            end else begin
                                c_d.lin = c_q.lin + STEP_T;
                            end
                        end
                        PH_LO_P: begin
                            if (test_pass) begin
                                c_d.lower = c_q.lin;
                                c_d.lin   = c_q.lin + UP_OFS;
                                c_d.ph    = PH_UP_CHK;
                            end else begin
                                c_d.lin = c_q.lin + STEP_P;
                            end
                        end
                        PH_UP_CHK: begin
                            if (test_pass) begin
                                c_d.lin = c_q.lin + STEP_T;
                                c_d.ph  = PH_UP_T;
                            end else begin
                                c_d.e_nar = 1'b1;
                                c_d.st    = ST_END;
                            end
                        end
                        PH_UP_T: begin
                            if (test_pass) begin
                                c_d.lin = c_q.lin + STEP_T;
                            end else begin
                                c_d.lin = c_q.lin - STEP_T;
                                c_d.ph  = PH_UP_P;
                            end
                        end
                        default: begin
                            if (test_pass) begin
                                c_d.lin = c_q.lin + STEP_P;
                            end else begin
                                c_d.lin = mid;
                                c_d.st  = ST_GDONE;
                            end
                        end
                    endcase
                end
            end
            ST_GDONE: begin
                c_d.grp = c_q.grp + 1'b1;
                c_d.st  = ST_SEL;
            end
            default: begin
                c_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, ph: PH_LO_T, grp: '0, lin: '0, lower: '0,
                     fast: 1'b0, e_ovf: 1'b0, e_nar: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign test_req     = (c_q.st == ST_WAIT);
    assign test_grp     = grp_idx;
    assign test_word    = enc_word;
    assign res_valid    = (c_q.st == ST_GDONE);
    assign res_grp      = grp_idx;
    assign res_word     = enc_word;
    assign busy         = (c_q.st != ST_IDLE);
    assign run_done     = (c_q.st == ST_END);
    assign err_overflow = c_q.e_ovf;
    assign err_narrow   = c_q.e_nar;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        test_req && !test_done |=> test_req) else $error("req dropped"); // R12
    AST_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        test_req && !test_done |=> $stable(test_word) && $stable(test_grp)) else $error("word moved"); // R12
    AST_T_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        test_req |-> test_word[T_LSB +: T_BITS] < tmod_w) else $error("t out of range"); // R1
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_overflow && !start |=> err_overflow) else $error("overflow flag lost"); // R2
    AST_NARROW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_narrow && !start |=> err_narrow) else $error("narrow flag lost"); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !test_req && !res_valid) else $error("activity while idle"); // R11
endmodule

// File: tb/sim_wr_delay_center.sv
`timescale 1ns/1ps
module sim_wr_delay_center;
    localparam int NGRP   = 4;
    localparam int MASK_W = 32;
    localparam int MAXE   = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic fast_mode = 1'b0;
    logic [NGRP*MASK_W-1:0] grp_mask_a = '0;
    logic [NGRP*MASK_W-1:0] grp_mask_b = '0;
    logic [NGRP*32-1:0]     init_words = '0;
    logic test_req;
    logic [1:0] test_grp;
    logic [31:0] test_word;
    logic test_done = 1'b0;
    logic test_pass = 1'b0;
    logic res_valid;
    logic [1:0] res_grp;
    logic [31:0] res_word;
    logic busy, run_done, err_overflow, err_narrow;

    always #2 clk = ~clk;

    wr_delay_center #(.NGRP(NGRP), .MASK_W(MASK_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .fast_mode(fast_mode),
        .grp_mask_a(grp_mask_a), .grp_mask_b(grp_mask_b), .init_words(init_words),
        .test_req(test_req), .test_grp(test_grp), .test_word(test_word),
        .test_done(test_done), .test_pass(test_pass),
        .res_valid(res_valid), .res_grp(res_grp), .res_word(res_word),
        .busy(busy), .run_done(run_done),
        .err_overflow(err_overflow), .err_narrow(err_narrow)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int win_lo [NGRP];
    int win_hi [NGRP];
    bit cur_fast;

    logic [31:0] exp_word [MAXE];
    int          exp_grp  [MAXE];
    int          exp_ph   [MAXE];
    int          n_exp;
    logic [31:0] exp_rword [NGRP];
    int          exp_rgrp  [NGRP];
    int          n_res;
    bit          exp_ovf, exp_nar;
    int          req_idx, res_idx;
    int          wait_cnt;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic int tm_of(input bit fm);
        return fm ? 12 : 11;
    endfunction

    function automatic logic [31:0] benc(input int lin, input logic [31:0] base, input bit fm);
        int tm, f, t, p, pe;
        logic [1:0] band;
        logic [31:0] w;
        tm = tm_of(fm);
        f  = lin / (tm * 8);
        t  = (lin / 8) % tm;
        p  = lin % 8;
        pe = p;
        if (fm && ((t == 9 && p >= 4) || (t == 10 && p < 4))) pe = 4;
        if (t <= (fm ? 2 : 1))      band = 2'b11;
        else if (t > (fm ? 9 : 6))  band = 2'b01;
        else                        band = 2'b00;
        w = base & 32'h08F0_FFFF;
        w[31:28] = t[3:0];
        w[26:24] = pe[2:0];
        w[19:18] = f[1:0];
        w[17:16] = band;
        return w;
    endfunction

    function automatic bit bpass(input logic [31:0] w, input int g, input bit fm);
        int lin;
        lin = (int'(w[19:18]) * tm_of(fm) + int'(w[31:28])) * 8 + int'(w[26:24]);
        return (lin >= win_lo[g]) && (lin <= win_hi[g]);
    endfunction

    task automatic build_model(input bit fm);
        bit stop;
        n_exp = 0; n_res = 0; exp_ovf = 0; exp_nar = 0; stop = 0;
        for (int g = 0; g < NGRP && !stop; g++) begin
            logic [31:0] base;
            int lin, lower, ph;
            bit gdone;
            if (grp_mask_a[g*MASK_W +: MASK_W] == 0 && grp_mask_b[g*MASK_W +: MASK_W] == 0) continue;
            base  = init_words[g*32 +: 32];
            lin   = ((int'(base[3:2]) - 1) * tm_of(fm) + int'(base[15:12])) * 8 + int'(base[10:8]);
            ph    = 0; lower = 0; gdone = 0;
            while (!gdone && !stop) begin
                logic [31:0] w;
                bit ps;
                if (lin < 0 || lin >= 32 * tm_of(fm) || n_exp >= MAXE - 1) begin
                    exp_ovf = 1; stop = 1;
                end else begin
                    w = benc(lin, base, fm);
                    exp_word[n_exp] = w; exp_grp[n_exp] = g;
                    exp_ph[n_exp] = (ph == 0 && lin == ((int'(base[3:2]) - 1) * tm_of(fm) + int'(base[15:12])) * 8 + int'(base[10:8])) ? 9 : ph;
                    n_exp++;
                    ps = bpass(w, g, fm);
                    case (ph)
                        0: if (ps) begin lin -= 8; ph = 1; end else lin += 8;
                        1: if (ps) begin lower = lin; lin += 24; ph = 2; end else lin += 1;
                        2: if (ps) begin lin += 8; ph = 3; end else begin exp_nar = 1; stop = 1; end
                        3: if (ps) lin += 8; else begin lin -= 8; ph = 4; end
                        default: if (ps) lin += 1;
                                 else begin
                                     exp_rword[n_res] = benc((lower + lin) / 2, base, fm);
                                     exp_rgrp[n_res]  = g;
                                     n_res++;
                                     gdone = 1;
                                 end
                    endcase
                end
            end
        end
    endtask

    // checker stand-in: answers requests and compares them with the model
    always @(negedge clk) begin
        if (test_done) begin
            test_done = 1'b0;
        end else if (test_req) begin
            if (wait_cnt > 0) begin
                wait_cnt--;
            end else begin
                if (req_idx < n_exp) begin
                    string tg;
                    case (exp_ph[req_idx])
                        9: tg = "R3 first position";
                        0, 1: tg = "R4 lower search";
                        2: tg = "R5 upper start";
                        default: tg = "R6 upper search";
                    endcase
                    check(test_word == exp_word[req_idx], tg, test_word, exp_word[req_idx]);
                    check(int'(test_grp) == exp_grp[req_idx], "R12 test_grp", 32'(test_grp), 32'(exp_grp[req_idx]));
                end else begin
                    check(1'b0, "R4 extra request", test_word, 32'h0);
                end
                req_idx++;
                test_pass = bpass(test_word, int'(test_grp), cur_fast);
                test_done = 1'b1;
                wait_cnt  = int'($urandom % 3);
            end
        end
    end

    always @(negedge clk) begin
        if (res_valid) begin
            if (res_idx < n_res) begin
                logic [31:0] e;
                string ptag;
                e = exp_rword[res_idx];
                ptag = (cur_fast && (e[31:28] == 4'd9 || e[31:28] == 4'd10)) ? "R10 p clamp" : "R8 p field";
                check(res_word[31:28] == e[31:28], "R1 R7 t field", res_word, e);
                check(res_word[19:18] == e[19:18], "R1 f field", res_word, e);
                check(res_word[26:24] == e[26:24], ptag, res_word, e);
                check(res_word[17:16] == e[17:16], "R9 band", res_word, e);
                check((res_word & 32'h08F0_FFFF) == (e & 32'h08F0_FFFF), "R8 kept bits", res_word, e);
                check(int'(res_grp) == exp_rgrp[res_idx], "R11 result group", 32'(res_grp), 32'(exp_rgrp[res_idx]));
            end else begin
                check(1'b0, "R11 extra result", res_word, 32'h0);
            end
            res_idx++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic run(input bit fm);
        int guard;
        @(negedge clk);
        cur_fast  = fm;
        fast_mode = fm;
        build_model(fm);
        req_idx = 0; res_idx = 0; wait_cnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (!run_done && guard < 30000) begin
            @(negedge clk);
            guard++;
        end
        check(run_done, "R2 run end", 32'(guard), 32'h0);
        @(negedge clk);
        check(req_idx == n_exp, "R4 R6 request count", 32'(req_idx), 32'(n_exp));
        check(res_idx == n_res, "R11 result count", 32'(res_idx), 32'(n_res));
        check(err_overflow == exp_ovf, "R2 overflow flag", 32'(err_overflow), 32'(exp_ovf));
        check(err_narrow == exp_nar, "R5 narrow flag", 32'(err_narrow), 32'(exp_nar));
        check(!busy, "R12 idle after run", 32'(busy), 32'h0);
    endtask

    function automatic logic [31:0] mk_init(input int f2, input int t, input int p);
        logic [31:0] w;
        w = $urandom;
        w[3:2]   = f2[1:0];
        w[15:12] = t[3:0];
        w[10:8]  = p[2:0];
        return w;
    endfunction

    task automatic all_groups(input int lo, input int hi);
        for (int g = 0; g < NGRP; g++) begin
            win_lo[g] = lo; win_hi[g] = hi;
            grp_mask_a[g*MASK_W +: MASK_W] = 32'h0000_00FF << (8 * (g % 4));
            grp_mask_b[g*MASK_W +: MASK_W] = '0;
        end
    endtask

    initial begin
        void'($urandom(32'd20240917));
        all_groups(60, 94);
        repeat (3) @(negedge clk);
        check(!busy && !test_req && !res_valid && !run_done, "reset outputs", 32'(busy), 32'h0);
        check(!err_overflow && !err_narrow, "reset flags", 32'(err_overflow), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: centre lands on t=9 p=5 in fast mode
        all_groups(60, 94);
        for (int g = 0; g < NGRP; g++) init_words[g*32 +: 32] = mk_init(1, 0, 0);
        run(1'b1);

        // R11: every group masked off
        grp_mask_a = '0; grp_mask_b = '0;
        run(1'b0);

        // R11: only groups 1 and 3, through the second mask
        all_groups(40, 120);
        grp_mask_a = '0;
        grp_mask_b[1*MASK_W +: MASK_W] = 32'h00FF_0000;
        grp_mask_b[3*MASK_W +: MASK_W] = 32'hFF00_0000;
        run(1'b0);

        // R2 R3: start position below zero
        all_groups(60, 94);
        for (int g = 0; g < NGRP; g++) init_words[g*32 +: 32] = mk_init(0, 0, 3);
        run(1'b0);

        // R5: window too narrow
        all_groups(50, 60);
        for (int g = 0; g < NGRP; g++) init_words[g*32 +: 32] = mk_init(1, 1, 0);
        run(1'b1);

        // R2: window open to the top, upper search overflows
        all_groups(30, 100000);
        run(1'b0);

        // R12: start while busy is ignored (checked through the normal run result)
        all_groups(70, 150);
        for (int g = 0; g < NGRP; g++) init_words[g*32 +: 32] = mk_init(1, 2, 1);
        fork
            run(1'b1);
            begin
                repeat (20) @(negedge clk);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join

        // random runs
        for (int r = 0; r < 40; r++) begin
            bit fm;
            fm = $urandom % 2;
            for (int g = 0; g < NGRP; g++) begin
                int lo;
                lo = 20 + int'($urandom % 220);
                win_lo[g] = lo;
                win_hi[g] = lo + 12 + int'($urandom % 110);
                grp_mask_a[g*MASK_W +: MASK_W] = ($urandom % 4 == 0) ? 32'h0 : $urandom | 32'h1;
                grp_mask_b[g*MASK_W +: MASK_W] = ($urandom % 2 == 0) ? 32'h0 : $urandom;
                init_words[g*32 +: 32] = mk_init(1 + int'($urandom % 2), int'($urandom % 6), int'($urandom % 8));
            end
            run(fm);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule